// File: doc/BRIEF.md
# NOR Flash Bus Interface Controller

This block turns single requests from on-chip logic into cycles on an external NOR-style memory bus with a 16-bit data path. A request names an address in halfword units, write data, a direction, a timing style (asynchronous or clocked) and, for clocked reads, a burst length and a wrap option. The controller generates the chip-select, address-valid, output-enable and write-enable strobes and the memory clock. It steers a split tri-state data bus (`dq_out`, `dq_oe`, `dq_in`) and samples the memory's WAIT line during clocked reads.

Requests enter on a valid/ready stream. A transfer happens on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the bus is idle and no read response is still waiting. Read data leaves on a second valid/ready stream. While `rsp_valid` is high and `rsp_ready` is low, the beat and its last flag are held unchanged. If this back-pressure arrives during a clocked burst, the controller suspends the burst. It stops the memory clock and lifts output-enable until the consumer takes the beat, then resumes.

Top module: `nor_bus_ctrl`

## Requirements
- R1: After reset and whenever the bus is idle, it is in standby: chip-select, address-valid, output-enable and write-enable are high, `dq_oe` is low, `mem_clk` is low, and `req_ready` is high once no response is pending.
- R2: An asynchronous read (`req_sync`=0, `req_write`=0) holds address-valid, chip-select and output-enable low with write-enable high and `mem_clk` low for ASYNC_CYC cycles. It then returns one beat carrying `dq_in` with `rsp_last`=1.
- R3: An asynchronous write holds address-valid, chip-select and write-enable low with output-enable high for ASYNC_CYC cycles, and drives `req_wdata` on `dq_out` with `dq_oe`=1.
- R4: A clocked read runs `mem_clk` at half the core rate, starting low. It captures `dq_in` at the end of each high phase, into beats for `mem_addr`. `req_blen` encodes the beat count as 0=1, 1=4, 2=8 and 3=16. `rsp_last` marks only the final beat.
- R5: A burst read with `req_wrap`=0 steps the address up by one per beat, carrying across any boundary.
- R6: A burst read with `req_wrap`=1 of N beats increments only the low log2(N) address bits, modulo N, so every beat stays inside the aligned N-halfword window.
- R7: While `mem_wait` is high at the end of a high clock phase, no beat is captured or counted and the address does not advance.
- R8: Burst suspend: when a clocked read holds an unaccepted beat at a low clock phase, `mem_clk` stays low, chip-select stays low, output-enable, write-enable and address-valid are high, and `dq_oe` is low until the beat is taken. The burst then continues.
- R9: A clocked write uses the same strobe levels as R3 for one full `mem_clk` period (low then high).
- R10: A write that follows a read is preceded by exactly one output-disable cycle. In that cycle chip-select is low, output-enable, write-enable and address-valid are high, and `dq_oe` is low.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_last` stay unchanged.
- R12: Output-enable and write-enable are never low together, and `dq_oe` is never high while output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = clocked access, 0 = asynchronous |
| req_blen | input | 2 | Clocked read burst length code (R4) |
| req_wrap | input | 1 | Wrap burst inside aligned window |
| req_addr | input | AW | Start address in halfwords |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read beat available |
| rsp_ready | input | 1 | Consumer takes the beat |
| rsp_data | output | DW | Read beat data |
| rsp_last | output | 1 | Final beat of the access |
| mem_clk | output | 1 | Memory clock |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wait | input | 1 | Memory stall, active high |
| mem_addr | output | AW | Current beat address |
| dq_out | output | DW | Data driven toward memory |
| dq_oe | output | 1 | Controller drives the data bus |
| dq_in | input | DW | Data from memory |

## Verification
On every cycle, the embedded properties check strobe exclusivity and bus contention, and the standby levels while chip-select is high. They also check that a read is followed by a released bus, that the output-disable state lasts one cycle, and that held beats stay stable. Further properties cover the stall while WAIT is high, the entry into suspend, the beat counter bound, and the address stepping, both linear and wrapped. The scenarios alone show the actual data order of bursts of each length, the exact strobe levels in each operation, and write data reaching the bus. They also show that a suspended burst resumes without losing or repeating a beat.

// File: rtl/nor_pkg.sv
package nor_pkg;

  localparam int BEAT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_ARD,
    ST_AWR,
    ST_SRD,
    ST_SWR,
    ST_SUSP
  } nor_state_e;

  typedef struct packed {
    logic clk_run;
    logic adv_n;
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } pin_lvl_t;

  function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] code);
    case (code)
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      2'd3:    return BEAT_W'(16);
      default: return BEAT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/nor_pin_table.sv
module nor_pin_table
  import nor_pkg::*;
(
  input  nor_state_e st,
  input  logic       phase,
  output pin_lvl_t   lvl,
  output logic       mem_clk
);

  always_comb begin
    case (st)
      ST_TURN: lvl = '{clk_run: 1'b0, adv_n: 1'b1, cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      ST_ARD:  lvl = '{clk_run: 1'b0, adv_n: 1'b0, cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      ST_AWR:  lvl = '{clk_run: 1'b0, adv_n: 1'b0, cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_SRD:  lvl = '{clk_run: 1'b1, adv_n: 1'b0, cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
      ST_SWR:  lvl = '{clk_run: 1'b1, adv_n: 1'b0, cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
      ST_SUSP: lvl = '{clk_run: 1'b0, adv_n: 1'b1, cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      default: lvl = '{clk_run: 1'b0, adv_n: 1'b1, cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    endcase
    mem_clk = lvl.clk_run & phase;
  end

endmodule

// File: rtl/nor_burst_addr.sv
module nor_burst_addr
  import nor_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [1:0]    load_blen,
  input  logic          load_wrap,
  input  logic          step,
  output logic [AW-1:0] addr
);

  localparam int PAD_W = AW - BEAT_W;

  logic [AW-1:0] addr_q, mask_q, inc;
  logic          wrap_q;

  assign inc  = addr_q + AW'(1);
  assign addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      wrap_q <= 1'b0;
    end else if (load) begin
      addr_q <= load_addr;
      mask_q <= {{PAD_W{1'b0}}, beats_of(load_blen) - BEAT_W'(1)};
      wrap_q <= load_wrap;
    end else if (step) begin
      if (wrap_q) addr_q <= (addr_q & ~mask_q) | (inc & mask_q);
      else        addr_q <= inc;
    end
  end

  p_wrap_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wrap_q) |=> (((addr_q ^ $past(addr_q)) & ~mask_q) == '0));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !wrap_q) |=> (addr_q == $past(addr_q) + AW'(1)));

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_pkg::*;
#(
  parameter int DW        = 16,
  parameter int ASYNC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_sync,
  input  logic [1:0]    req_blen,
  input  logic [DW-1:0] req_wdata,
  output logic          accept,
  output logic          step,
  input  logic          mem_wait,
  input  logic [DW-1:0] dq_in,
  output nor_state_e    st,
  output logic          phase,
  output logic [DW-1:0] wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last
);

  localparam int CNT_W = $clog2(ASYNC_CYC + 1);

  nor_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] beats_q, beat_cnt_q;
  logic              phase_q, last_rd_q, wr_sync_q;
  logic [DW-1:0]     wdata_q, rsp_data_q;
  logic              rsp_valid_q, rsp_last_q;
  logic              beat_now, final_beat;

  assign req_ready  = (st_q == ST_IDLE) && !rsp_valid_q;
  assign accept     = req_valid && req_ready;
  assign beat_now   = (st_q == ST_SRD) && phase_q && !mem_wait;
  assign final_beat = (beat_cnt_q == beats_q - BEAT_W'(1));
  assign step       = beat_now && !final_beat;

  assign st        = st_q;
  assign phase     = phase_q;
  assign wdata     = wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_last  = rsp_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      beats_q     <= BEAT_W'(1);
      beat_cnt_q  <= '0;
      phase_q     <= 1'b0;
      last_rd_q   <= 1'b0;
      wr_sync_q   <= 1'b0;
      wdata_q     <= '0;
      rsp_data_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_last_q  <= 1'b0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            wdata_q    <= req_wdata;
            wr_sync_q  <= req_sync;
            beats_q    <= req_sync ? beats_of(req_blen) : BEAT_W'(1);
            beat_cnt_q <= '0;
            cnt_q      <= CNT_W'(ASYNC_CYC - 1);
            phase_q    <= 1'b0;
            if (req_write) begin
              if (last_rd_q)     st_q <= ST_TURN;
              else if (req_sync) st_q <= ST_SWR;
              else               st_q <= ST_AWR;
            end else begin
              st_q <= req_sync ? ST_SRD : ST_ARD;
            end
          end
        end
        ST_TURN: begin
          st_q  <= wr_sync_q ? ST_SWR : ST_AWR;
          cnt_q <= CNT_W'(ASYNC_CYC - 1);
        end
        ST_ARD: begin
          if (cnt_q == '0) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= dq_in;
            rsp_last_q  <= 1'b1;
            last_rd_q   <= 1'b1;
            st_q        <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_AWR: begin
          if (cnt_q == '0) begin
            last_rd_q <= 1'b0;
            st_q      <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SWR: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q   <= 1'b0;
            last_rd_q <= 1'b0;
            st_q      <= ST_IDLE;
          end
        end
        ST_SRD: begin
          if (!phase_q) begin
            if (rsp_valid_q && !rsp_ready) st_q <= ST_SUSP;
            else                           phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (beat_now) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= dq_in;
              rsp_last_q  <= final_beat;
              beat_cnt_q  <= beat_cnt_q + BEAT_W'(1);
              if (final_beat) begin
                last_rd_q <= 1'b1;
                st_q      <= ST_IDLE;
              end
            end
          end
        end
        ST_SUSP: begin
          if (rsp_ready) st_q <= ST_SRD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_data_q) && $stable(rsp_last_q)));

  p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cnt_q <= beats_q);

  p_wait_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRD && phase_q && mem_wait) |=> $stable(beat_cnt_q));

  p_suspend_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SRD && !phase_q && rsp_valid_q && !rsp_ready) |=> (st_q == ST_SUSP && !phase_q));

  p_turn_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TURN) |=> (st_q == ST_AWR || st_q == ST_SWR));

endmodule

// File: rtl/nor_bus_ctrl.sv
module nor_bus_ctrl
  import nor_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int ASYNC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_sync,
  input  logic [1:0]    req_blen,
  input  logic          req_wrap,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last,
  output logic          mem_clk,
  output logic          mem_adv_n,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  input  logic          mem_wait,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  nor_state_e st;
  pin_lvl_t   lvl;
  logic       phase, accept, step;

  nor_seq #(.DW(DW), .ASYNC_CYC(ASYNC_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_sync  (req_sync),
    .req_blen  (req_blen),
    .req_wdata (req_wdata),
    .accept    (accept),
    .step      (step),
    .mem_wait  (mem_wait),
    .dq_in     (dq_in),
    .st        (st),
    .phase     (phase),
    .wdata     (dq_out),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  nor_burst_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .load_blen (req_blen),
    .load_wrap (req_wrap),
    .step      (step),
    .addr      (mem_addr)
  );

  nor_pin_table u_pins (
    .st      (st),
    .phase   (phase),
    .lvl     (lvl),
    .mem_clk (mem_clk)
  );

  assign mem_adv_n = lvl.adv_n;
  assign mem_cs_n  = lvl.cs_n;
  assign mem_oe_n  = lvl.oe_n;
  assign mem_we_n  = lvl.we_n;
  assign dq_oe     = lvl.drive;

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_no_contention_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n);

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && mem_adv_n && !dq_oe && !mem_clk));

  p_read_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !dq_oe);

  p_suspend_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n) |-> !mem_clk);

endmodule

// File: tb/nor_bus_ctrl_tb.sv
`timescale 1ns/1ps
module nor_bus_ctrl_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_sync = 1'b0, req_wrap = 1'b0;
  logic [1:0]    req_blen = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_last;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data, dq_out, dq_in;
  logic          mem_clk, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe;
  logic          mem_wait = 1'b0;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic wrap, input int n);
    logic [AW-1:0] m;
    m = AW'(n - 1);
    return wrap ? ((a & ~m) | ((a + AW'(1)) & m)) : a + AW'(1);
  endfunction

  assign dq_in = mdat(mem_addr);

  nor_bus_ctrl #(.AW(AW), .DW(DW), .ASYNC_CYC(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sync(req_sync), .req_blen(req_blen), .req_wrap(req_wrap),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .mem_clk(mem_clk), .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_wait(mem_wait), .mem_addr(mem_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Write capture and R12 exclusivity monitor
  always @(negedge clk) begin
    if (rst_n && !mem_cs_n) begin
      if (!mem_we_n && dq_oe) begin
        wr_addr = mem_addr;
        wr_data = dq_out;
      end
      check(!( !mem_oe_n && (!mem_we_n || dq_oe)), "R12",
            {29'd0, mem_oe_n, mem_we_n, dq_oe}, 32'd4);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // {write, sync, blen[1:0], wrap, addr[15:0], wdata[15:0]}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 1'b0, 16'h0123, 16'h0000},
    {1'b1, 1'b0, 2'd0, 1'b0, 16'h0040, 16'hBEEF},
    {1'b0, 1'b1, 2'd0, 1'b0, 16'h0200, 16'h0000},
    {1'b1, 1'b1, 2'd0, 1'b0, 16'h0300, 16'h1234},
    {1'b0, 1'b1, 2'd1, 1'b0, 16'h0102, 16'h0000},
    {1'b0, 1'b1, 2'd2, 1'b1, 16'h0105, 16'h0000},
    {1'b0, 1'b1, 2'd3, 1'b1, 16'h021E, 16'h0000},
    {1'b0, 1'b1, 2'd2, 1'b0, 16'h03FE, 16'h0000},
    {1'b1, 1'b0, 2'd0, 1'b0, 16'h0050, 16'h5A5A}
  };

  task automatic issue(input logic [36:0] v);
    @(negedge clk);
    req_write = v[36]; req_sync = v[35]; req_blen = v[34:33]; req_wrap = v[32];
    req_addr = {4'h0, v[31:16]}; req_wdata = v[15:0];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input logic [AW-1:0] base, input logic wrap, input int n, input string tag);
    logic [AW-1:0] a;
    int got, guard;
    a = base; got = 0; guard = 0;
    while (got < n && guard < 400) begin
      if (rsp_valid && rsp_ready) begin
        check(rsp_data == mdat(a), tag, {16'd0, rsp_data}, {16'd0, mdat(a)});
        check(rsp_last == (got == n - 1), "R4", {31'd0, rsp_last}, {31'd0, got == n - 1});
        a = nxt(a, wrap, n);
        got++;
      end
      @(negedge clk);
      guard++;
    end
    check(got == n, tag, got, n);
  endtask

  function automatic int nbeats(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 16;
  endfunction

  initial begin
    logic prev_rd;
    logic [36:0] v;
    string tag;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset / standby
    check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b111100, "R1",
          {26'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h3C);
    check(req_ready && !rsp_valid, "R1", {30'd0, req_ready, rsp_valid}, 32'd2);

    prev_rd = 1'b0;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      issue(v);
      if (!v[36]) begin
        if (!v[35]) begin
          check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b000100, "R2",
                {26'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h04);
          collect({4'h0, v[31:16]}, 1'b0, 1, "R2");
        end else begin
          check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b000100, "R4",
                {26'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h04);
          @(negedge clk);
          check(mem_clk == 1'b1, "R4", {31'd0, mem_clk}, 32'd1);
          tag = (v[34:33] == 2'd0) ? "R4" : (v[32] ? "R6" : "R5");
          collect({4'h0, v[31:16]}, v[32], nbeats(v[34:33]), tag);
        end
      end else begin
        tag = v[35] ? "R9" : "R3";
        if (prev_rd) begin
          check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b101100, "R10",
                {26'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h2C);
          @(negedge clk);
        end
        check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe} == 5'b00101, tag,
              {27'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe}, 32'h05);
        check(dq_out == v[15:0], tag, {16'd0, dq_out}, {16'd0, v[15:0]});
        if (v[35]) begin
          @(negedge clk);
          check(mem_clk == 1'b1, "R9", {31'd0, mem_clk}, 32'd1);
        end
        while (!req_ready) @(negedge clk);
        check(wr_addr == {4'h0, v[31:16]} && wr_data == v[15:0], tag,
              {wr_addr[15:0], wr_data}, {v[31:16], v[15:0]});
      end
      prev_rd = !v[36];
    end

    // R8 / R11: burst suspend under back-pressure
    rsp_ready = 1'b0;
    issue({1'b0, 1'b1, 2'd2, 1'b0, 16'h0010, 16'h0000});
    for (int g = 0; g < 50 && !rsp_valid; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b101100, "R8",
          {26'd0, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h2C);
    check(rsp_valid && rsp_data == mdat(20'h00010), "R11", {15'd0, rsp_valid, rsp_data},
          {15'd0, 1'b1, mdat(20'h00010)});
    rsp_ready = 1'b1;
    collect(20'h00010, 1'b0, 8, "R8");

    // R7: WAIT held high stalls the burst
    mem_wait = 1'b1;
    issue({1'b0, 1'b1, 2'd1, 1'b0, 16'h0020, 16'h0000});
    repeat (10) @(negedge clk);
    check(!rsp_valid && !mem_oe_n, "R7", {30'd0, rsp_valid, mem_oe_n}, 32'd0);
    mem_wait = 1'b0;
    collect(20'h00020, 1'b0, 4, "R7");

    // R1: back to standby
    repeat (2) @(negedge clk);
    check({mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk} == 6'b111100 && req_ready, "R1",
          {25'd0, req_ready, mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, dq_oe, mem_clk}, 32'h7C);
    finish_run();
  end

endmodule